// File: doc/BRIEF.md
# Nine-bit word byte packer

This block lets a serializer that can only send 8-bit frames carry a 9-bit word protocol. Each input beat carries one byte and a flag saying whether the byte is data or a command. The block turns the beat into a 9-bit word whose top bit is that flag. It collects words into groups of eight and sends every group as nine bytes, packed densely with no gaps. The most significant bit goes first.

A transfer ends with the beat that carries the last marker. When a transfer does not fill its final group, the block fills the group with all-zero words, which the receiving device treats as no-ops. For a data transfer the fillers follow the real words. For a command transfer they come before the real words, so the receiver reads the no-ops first and the command closes the group. The output stream marks the ninth byte of the final group of a transfer.

Top module: `nb_packer`

## Requirements
- R1: An input beat becomes the 9-bit word {in_is_data, in_byte}: bit 8 is 1 for data and 0 for a command, and bits 7:0 are the byte.
- R2: Eight words form one 72-bit group, sent as nine bytes. Word 0 occupies group bits 71:63 and each following word takes the next nine bits down. The group is sent from bit 71 downward, so byte b carries group bits 71-8b down to 64-8b.
- R3: A data transfer of n words, where n mod 8 is not 0, is followed by 8 - (n mod 8) all-zero words inside its final group.
- R4: A command transfer puts its 8 - (n mod 8) all-zero words at the start of its final group, ahead of the real words. The transfer kind is taken from the flag of the beat that carries in_last.
- R5: A transfer whose length is a multiple of 8 gets no padding and produces exactly n/8 groups.
- R6: out_last is high only on the ninth byte of the final group of a transfer. The full groups before it are sent without the marker.
- R7: While out_valid is high and out_ready is low, out_byte and out_last hold steady. While a group is being sent, in_ready stays low, and no bit is lost.
- R8: After reset, and again once a group's ninth byte has been taken, out_valid is low and in_ready is high.
- R9: The first byte of a group is offered in the cycle after the clock edge that accepts the word closing that group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Block can take an input beat |
| in_byte | input | 8 | Payload byte of the beat |
| in_is_data | input | 1 | 1: data word, 0: command word |
| in_last | input | 1 | Beat ends the transfer |
| out_valid | output | 1 | Output byte offered |
| out_ready | input | 1 | Consumer takes the output byte |
| out_byte | output | 8 | Packed output byte |
| out_last | output | 1 | Ninth byte of the transfer's final group |

## Verification
One clock edge accepts the word that closes a group, and the first packed byte is valid in the following cycle. The bench checks out_valid at the falling edge just after that accepting edge. Each later byte moves forward one edge after a handshake, so the collector records a byte at the falling edge where both valid and ready are high. The collector then checks the idle state one falling edge after the ninth byte has been taken. Stall cycles on out_ready are mixed in, and at each of these the bench checks that the byte offered has not changed.

// File: rtl/nb_pkg.sv
// Shared constants and the word-forming function for the nine-bit packer.
// Assumes the word width is one more than the byte width.
package nb_pkg;
    localparam int BYTE_W_DEF  = 8;
    localparam int GROUP_W_DEF = 8;

    // Put the command/data flag on top of the payload byte.
    function automatic logic [BYTE_W_DEF:0] nb_make_word(input logic is_data,
                                                          input logic [BYTE_W_DEF-1:0] b);
        return {is_data, b};
    endfunction
endpackage

// File: rtl/nb_word_form.sv
// Builds one protocol word from an input beat.
// Assumes BYTE_W matches the package default used by the word function.
module nb_word_form #(
    parameter int BYTE_W = nb_pkg::BYTE_W_DEF
) (
    input  logic              is_data,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W:0]   word
);
    // Flag goes in the most significant bit.
    always_comb word = nb_pkg::nb_make_word(is_data, byte_in);
endmodule

// File: rtl/nb_align.sv
// Places a partly filled group. Words are shifted in at the low end, so the
// unused high positions are already zero, and that is command padding. For
// data the words are moved up so that the zeros trail them.
module nb_align #(
    parameter int WORD_W  = 9,
    parameter int GROUP   = 8,
    parameter int CNT_W   = 4,
    localparam int GBITS  = WORD_W * GROUP
) (
    input  logic [GBITS-1:0] acc,
    input  logic [CNT_W-1:0] n_words,
    input  logic             is_data,
    output logic [GBITS-1:0] aligned
);
    int unsigned sh;

    // Shift data words up by the number of missing word slots.
    always_comb begin
        sh      = (GROUP - 32'(n_words)) * WORD_W;
        aligned = is_data ? (acc << sh) : acc;
    end
endmodule

// File: rtl/nb_packer.sv
// Nine-bit word byte packer top. It fills a group register word by word, then
// sends the group one byte at a time from the top. Input is stalled while a
// group is sent. Synchronous active-low reset.
module nb_packer #(
    parameter int BYTE_W = nb_pkg::BYTE_W_DEF,
    parameter int GROUP  = nb_pkg::GROUP_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_is_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last
);
    localparam int WORD_W = BYTE_W + 1;
    localparam int GBITS  = WORD_W * GROUP;
    localparam int NBYTES = GBITS / BYTE_W;
    localparam int CNT_W  = $clog2(GROUP + 1);
    localparam int IDX_W  = $clog2(NBYTES + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(GROUP - 1);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(NBYTES - 1);

    logic [GBITS-1:0]  stage;
    logic [GBITS-1:0]  acc_next;
    logic [GBITS-1:0]  aligned;
    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  wcnt;
    logic [IDX_W-1:0]  bidx;
    logic              draining;
    logic              grp_last;

    nb_word_form #(.BYTE_W(BYTE_W)) u_form (
        .is_data (in_is_data),
        .byte_in (in_byte),
        .word    (word)
    );

    // Candidate group with the current word shifted in at the bottom.
    always_comb acc_next = {stage[GBITS-WORD_W-1:0], word};

    nb_align #(.WORD_W(WORD_W), .GROUP(GROUP), .CNT_W(CNT_W)) u_align (
        .acc     (acc_next),
        .n_words (wcnt + CNT_W'(1)),
        .is_data (in_is_data),
        .aligned (aligned)
    );

    // Fill the group, then shift it out a byte per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage    <= '0;
            wcnt     <= '0;
            bidx     <= '0;
            draining <= 1'b0;
            grp_last <= 1'b0;
        end else if (!draining) begin
            if (in_valid) begin
                if (wcnt == LAST_SLOT || in_last) begin
                    stage    <= aligned;
                    wcnt     <= '0;
                    bidx     <= '0;
                    draining <= 1'b1;
                    grp_last <= in_last;
                end else begin
                    stage <= acc_next;
                    wcnt  <= wcnt + CNT_W'(1);
                end
            end
        end else if (out_ready) begin
            stage <= stage << BYTE_W;
            if (bidx == LAST_BYTE) begin
                draining <= 1'b0;
                bidx     <= '0;
            end else begin
                bidx <= bidx + IDX_W'(1);
            end
        end
    end

    // Output view of the group register and handshake flags.
    always_comb begin
        in_ready  = !draining;
        out_valid = draining;
        out_byte  = stage[GBITS-1 -: BYTE_W];
        out_last  = draining && grp_last && (bidx == LAST_BYTE);
    end
endmodule

// File: rtl/nb_packer_chk.sv
// Protocol checker for the packer, bound to every instance of the top.
module nb_packer_chk #(
    parameter int BYTE_W = 8,
    parameter int GROUP  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_byte,
    input logic              out_last
);
    localparam int NBYTES = ((BYTE_W + 1) * GROUP) / BYTE_W;
    int unsigned ck_b;
    int unsigned ck_w;

    // Count bytes taken within a group and words taken within a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_b <= 0;
            ck_w <= 0;
        end else begin
            if (out_valid && out_ready) ck_b <= (ck_b == NBYTES - 1) ? 0 : ck_b + 1;
            if (in_valid && in_ready)
                ck_w <= (in_last || ck_w == GROUP - 1) ? 0 : ck_w + 1;
        end
    end

    AST_IN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last))); // R7
    AST_LAST_NINTH: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> (ck_b == NBYTES - 1)); // R6
    AST_GROUP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && ck_b == NBYTES - 1) |=> !out_valid); // R8
    AST_START_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready && (in_last || ck_w == GROUP - 1))); // R9
endmodule

bind nb_packer nb_packer_chk #(.BYTE_W(BYTE_W), .GROUP(GROUP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_byte  (out_byte),
    .out_last  (out_last)
);

// File: tb/tb_nb_packer.sv
// Directed bench: one task per scenario, each checking its own bytes.
module tb_nb_packer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = '0;
    logic       in_is_data = 1'b0;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_byte;
    logic       out_last;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [8:0] padded [0:255];
    logic [7:0] exp_b  [0:287];
    logic       exp_l  [0:287];
    int         exp_n;

    always #5 clk = ~clk;

    nb_packer dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_data(in_is_data), .in_last(in_last),
        .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
        .out_last(out_last)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int seed);
        return 8'((k * 37 + seed) & 255);
    endfunction

    // Build the expected byte stream from the requirements.
    task automatic build_exp(input int n, input bit is_data, input int seed);
        int g = (n + 7) / 8;
        int p = g * 8 - n;
        for (int i = 0; i < g * 8; i++) padded[i] = 9'h000;
        for (int i = 0; i < n; i++) begin
            if (is_data || i < (g - 1) * 8) padded[i] = {is_data, pat(i, seed)};
            else padded[i + p] = {1'b0, pat(i, seed)};
        end
        exp_n = 0;
        for (int gi = 0; gi < g; gi++) begin
            logic [71:0] gv = '0;
            for (int w = 0; w < 8; w++) gv = {gv[62:0], padded[gi * 8 + w]};
            for (int b = 0; b < 9; b++) begin
                exp_b[exp_n] = gv[71 - 8 * b -: 8];
                exp_l[exp_n] = (gi == g - 1) && (b == 8);
                exp_n++;
            end
        end
    endtask

    // Drive one transfer, collect its bytes with an out_ready stall pattern.
    task automatic run_xfer(input string req, input int n, input bit is_data,
                            input int seed, input int stall);
        build_exp(n, is_data, seed);
        fork
            begin
                for (int k = 0; k < n; k++) begin
                    @(negedge clk);
                    in_valid = 1'b1; in_byte = pat(k, seed);
                    in_is_data = is_data; in_last = (k == n - 1);
                    while (!in_ready) @(negedge clk);
                end
                @(negedge clk);
                in_valid = 1'b0; in_last = 1'b0;
                check("R9", "out_valid after closing word", int'(out_valid), 1);
            end
            begin
                int got = 0;
                int cyc = 0;
                bit held = 1'b0;
                logic [7:0] hb = '0;
                while (got < exp_n) begin
                    @(negedge clk);
                    if (held) check("R7", "held byte", int'(out_byte), int'(hb));
                    out_ready = (stall == 0) || ((cyc % stall) != 0);
                    cyc++;
                    held = out_valid && !out_ready;
                    hb = out_byte;
                    if (out_valid && out_ready) begin
                        check(req, $sformatf("byte %0d", got), int'(out_byte), int'(exp_b[got]));
                        check("R6", $sformatf("last %0d", got), int'(out_last), int'(exp_l[got]));
                        got++;
                    end
                end
                @(negedge clk);
                out_ready = 1'b0;
                check("R8", "idle out_valid", int'(out_valid), 0);
                check("R8", "idle in_ready", int'(in_ready), 1);
            end
        join
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R8", "reset out_valid", int'(out_valid), 0);
        check("R8", "reset in_ready", int'(in_ready), 1);
    endtask

    task automatic t_full_data();      run_xfer("R2", 8, 1'b1, 5, 0);   endtask // R1 R2 R5
    task automatic t_cmd_single();     run_xfer("R4", 1, 1'b0, 42, 0);  endtask // pads lead
    task automatic t_data_short();     run_xfer("R3", 3, 1'b1, 9, 3);   endtask // pads trail
    task automatic t_data_multi();     run_xfer("R3", 19, 1'b1, 77, 2); endtask // R6 across groups
    task automatic t_cmd_long();       run_xfer("R4", 10, 1'b0, 13, 4); endtask
    task automatic t_exact_two();      run_xfer("R5", 16, 1'b0, 200, 3); endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_full_data();
        t_cmd_single();
        t_data_short();
        t_data_multi();
        t_cmd_long();
        t_exact_two();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule